// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy check over a message that arrives one bit per clock, most significant bit first. It performs modulo-2 long division in a shift register of polynomial width. An XOR gate sits at each nonzero term of the divisor, so a bit is either added in or passes straight through. The divisor is a parameter. By default it is the 12-bit polynomial x^12 + x^11 + x^3 + x^2 + x + 1.

A frame opens with a start pulse. At that pulse the direction is latched and the register clears.

- **Transmit:** the caller streams the data bits and marks the last one with the end flag. The block then emits the 12 remainder bits on its serial output, so that data followed by remainder divides evenly by the polynomial.
- **Receive:** the caller streams the whole frame, data followed by check bits, through the same register. One cycle after the last bit, the block reports whether the remainder is zero.

Top module: `crc_serial`

## Requirements
- R1: After reset, tx_valid_o, tx_bit_o, err_valid_o and err_o are all 0.
- R2: A sof_i pulse clears the remainder to zero and abandons any frame in progress, so the result depends only on bits accepted after the latest sof_i.
- R3: In transmit mode (mode_i = 0 at sof_i), tx_bit_o carries the remainder of (data * x^W) divided by the polynomial, most significant bit first. The first remainder bit appears in the cycle after the data bit flagged with eod_i.
- R4: tx_valid_o is high for exactly W consecutive cycles after the last data bit, then drops.
- R5: In receive mode (mode_i = 1 at sof_i), err_valid_o rises in the cycle after the frame bit flagged with eod_i. err_o is 0 when the frame is exactly divisible by the polynomial.
- R6: A received frame carrying a single flipped bit, or a burst of flipped bits no longer than W, gives err_o = 1.
- R7: err_o and err_valid_o hold their values until the next sof_i, which clears err_valid_o in the following cycle.
- R8: Cycles with bit_valid_i = 0 inside a frame do not change the result, whatever value bit_i has.
- R9: Valid bits presented outside a frame are ignored, and so are valid bits presented while the remainder is being shifted out.
- R10: mode_i is sampled only at sof_i, and changing it during a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Direction, sampled at sof_i: 0 transmit, 1 receive |
| sof_i | input | 1 | Start of frame; clears the remainder |
| bit_valid_i | input | 1 | bit_i carries a message bit this cycle |
| bit_i | input | 1 | Serial message bit, MSB first |
| eod_i | input | 1 | With bit_valid_i, marks the last data bit (transmit) or the last frame bit (receive) |
| tx_bit_o | output | 1 | Serial remainder bit, MSB first |
| tx_valid_o | output | 1 | tx_bit_o is a remainder bit |
| err_o | output | 1 | Nonzero remainder on the received frame |
| err_valid_o | output | 1 | err_o is valid for the last received frame |

## Verification
The bench computes every expected remainder by textbook polynomial long division of the padded message.

- **Bit order and padding:** messages of 1 to 32 bits are covered. A design that shifted LSB first, or omitted the x^W padding, would produce a different check sequence.
- **Mode handling:** mode_i is flipped right after every start pulse. A design that did not latch the mode would switch function mid-frame.
- **Idle and shift-out bits:** garbage valid bits, including stray end flags, are driven during shift-out and after a receive result. They catch feedback left enabled while shifting out, and a flag that does not hold.
- **Gaps and restarts:** gapped input catches bits sampled without their valid. A restarted frame exposes a register that is not cleared at the start pulse.
- **Corruption:** single-bit flips and an 8-bit burst in received frames catch a checker that misses nonzero remainders.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;
  typedef enum logic [1:0] {OP_HOLD, OP_DIV, OP_SHL} div_op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_APPEND} ctrl_st_e;
  localparam logic MODE_TX = 1'b0;
  localparam logic MODE_RX = 1'b1;
endpackage

// File: rtl/crc_div_reg.sv
module crc_div_reg
  import crc_serial_pkg::*;
#(
  parameter int          W    = 12,
  parameter logic [W-1:0] POLY = 12'h80F
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  div_op_e      op_i,
  input  logic         bit_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] rem_next_o
);
  logic [W-1:0] rem_q, base, div_val, shl_val, nxt;
  logic         fb;

  assign base    = clr_i ? '0 : rem_q;
  assign fb      = base[W-1] ^ bit_i;
  assign shl_val = {base[W-2:0], 1'b0};

  // xor only where the divisor has a term
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      if (POLY[0]) begin : g_x
        assign div_val[0] = fb;
      end else begin : g_p
        assign div_val[0] = 1'b0;
      end
    end else begin : g_mid
      if (POLY[i]) begin : g_x
        assign div_val[i] = base[i-1] ^ fb;
      end else begin : g_p
        assign div_val[i] = base[i-1];
      end
    end
  end

  always_comb begin
    unique case (op_i)
      OP_DIV:  nxt = div_val;
      OP_SHL:  nxt = shl_val;
      default: nxt = base;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= '0;
    else         rem_q <= nxt;
  end

  assign rem_o      = rem_q;
  assign rem_next_o = nxt;

  AST_SOF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && op_i == OP_HOLD) |=> (rem_o == '0)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && op_i == OP_HOLD) |=> $stable(rem_o)); // R9
endmodule

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_serial_pkg::*;
#(
  parameter int W = 12
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    mode_i,
  input  logic    sof_i,
  input  logic    bit_valid_i,
  input  logic    eod_i,
  output logic    clr_o,
  output div_op_e op_o,
  output logic    tx_valid_o,
  output logic    last_rx_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  ctrl_st_e       st_q, st_d;
  logic           mode_q, mode_eff;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           body_now, last_bit;

  assign body_now = sof_i || (st_q == ST_BODY);
  assign mode_eff = sof_i ? mode_i : mode_q;
  assign last_bit = body_now && bit_valid_i && eod_i;
  assign clr_o    = sof_i;
  assign last_rx_o = last_bit && (mode_eff == MODE_RX);
  assign tx_valid_o = (st_q == ST_APPEND);

  always_comb begin
    if (body_now && bit_valid_i)              op_o = OP_DIV;
    else if (st_q == ST_APPEND && !sof_i)     op_o = OP_SHL;
    else                                      op_o = OP_HOLD;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (last_bit) begin
      st_d  = (mode_eff == MODE_TX) ? ST_APPEND : ST_IDLE;
      cnt_d = '0;
    end else if (sof_i) begin
      st_d = ST_BODY;
    end else if (st_q == ST_APPEND) begin
      if (cnt_q == CW'(W - 1)) st_d = ST_IDLE;
      else                     cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= MODE_TX;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (sof_i) mode_q <= mode_i;
    end
  end

  AST_TXV_AFTER_EOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(bit_valid_i && eod_i)); // R3
endmodule

// File: rtl/crc_check.sv
module crc_check #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sof_i,
  input  logic         last_rx_i,
  input  logic [W-1:0] rem_next_i,
  output logic         err_o,
  output logic         err_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o       <= 1'b0;
      err_valid_o <= 1'b0;
    end else if (last_rx_i) begin
      err_o       <= |rem_next_i;
      err_valid_o <= 1'b1;
    end else if (sof_i) begin
      err_o       <= 1'b0;
      err_valid_o <= 1'b0;
    end
  end

  AST_ERRV_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_valid_o) |-> $past(last_rx_i)); // R5
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_o && !sof_i && !last_rx_i) |=> (err_valid_o && $stable(err_o))); // R7
endmodule

// File: rtl/crc_serial.sv
module crc_serial
  import crc_serial_pkg::*;
#(
  parameter int           W    = 12,
  parameter logic [W-1:0] POLY = 12'h80F
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic sof_i,
  input  logic bit_valid_i,
  input  logic bit_i,
  input  logic eod_i,
  output logic tx_bit_o,
  output logic tx_valid_o,
  output logic err_o,
  output logic err_valid_o
);
  div_op_e      op;
  logic         clr, last_rx;
  logic [W-1:0] rem, rem_next;

  crc_ctrl #(.W(W)) u_ctrl (
    .clk_i, .rst_ni, .mode_i, .sof_i, .bit_valid_i, .eod_i,
    .clr_o(clr), .op_o(op), .tx_valid_o, .last_rx_o(last_rx)
  );

  crc_div_reg #(.W(W), .POLY(POLY)) u_div (
    .clk_i, .rst_ni, .clr_i(clr), .op_i(op), .bit_i,
    .rem_o(rem), .rem_next_o(rem_next)
  );

  crc_check #(.W(W)) u_chk (
    .clk_i, .rst_ni, .sof_i, .last_rx_i(last_rx), .rem_next_i(rem_next),
    .err_o, .err_valid_o
  );

  assign tx_bit_o = tx_valid_o & rem[W-1];
endmodule

// File: tb/crc_serial_tb.sv
module crc_serial_tb;
  localparam int W = 12;
  localparam logic [W:0] P_FULL = 13'h180F;

  typedef struct packed {
    logic        md;
    logic [5:0]  len;
    logic [31:0] data;
    logic [43:0] flip;
    logic        gaps;
    logic        exp_err;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd8,  32'h0000_00A5, 44'h0,             1'b0, 1'b0},
    '{1'b0, 6'd16, 32'h0000_BEEF, 44'h0,             1'b1, 1'b0},
    '{1'b0, 6'd1,  32'h0000_0001, 44'h0,             1'b0, 1'b0},
    '{1'b0, 6'd32, 32'hFFFF_FFFF, 44'h0,             1'b1, 1'b0},
    '{1'b0, 6'd12, 32'h0000_0000, 44'h0,             1'b0, 1'b0},
    '{1'b1, 6'd8,  32'h0000_00A5, 44'h0,             1'b0, 1'b0},
    '{1'b1, 6'd16, 32'h0000_1234, 44'h1,             1'b1, 1'b1},
    '{1'b1, 6'd24, 32'h00C0_FFEE, 44'h000_0FF0_0000, 1'b0, 1'b1},
    '{1'b1, 6'd32, 32'hDEAD_BEEF, 44'h0,             1'b1, 1'b0},
    '{1'b1, 6'd20, 32'h0000_0000, 44'h000_4000_0000, 1'b0, 1'b1}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mode_i = 1'b0, sof_i = 1'b0, bit_valid_i = 1'b0, bit_i = 1'b0, eod_i = 1'b0;
  logic tx_bit_o, tx_valid_o, err_o, err_valid_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  crc_serial #(.W(W), .POLY(P_FULL[W-1:0])) u_dut (
    .clk_i, .rst_ni, .mode_i, .sof_i, .bit_valid_i, .bit_i, .eod_i,
    .tx_bit_o, .tx_valid_o, .err_o, .err_valid_o
  );

  function automatic logic [W-1:0] poly_mod(input logic [75:0] v);
    logic [75:0] r = v;
    for (int i = 75; i >= W; i--)
      if (r[i]) r = r ^ ({63'b0, P_FULL} << (i - W));
    return r[W-1:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // sof, then bits MSB first; mode_i flipped after sof (R10)
  task automatic send(input logic md, input int len, input logic [63:0] bits, input logic gaps);
    sof_i = 1'b1; mode_i = md; bit_valid_i = 1'b0; eod_i = 1'b0;
    @(negedge clk_i);
    sof_i = 1'b0; mode_i = ~md;
    for (int i = len - 1; i >= 0; i--) begin
      bit_valid_i = 1'b1; bit_i = bits[i]; eod_i = (i == 0);
      @(negedge clk_i);
      if (gaps && (i % 3 == 0) && i != 0) begin
        bit_valid_i = 1'b0; bit_i = ~bit_i; eod_i = 1'b1;
        @(negedge clk_i);
      end
    end
    bit_valid_i = 1'b0; eod_i = 1'b0;
  endtask

  // collect remainder while driving garbage valid bits (R9)
  task automatic collect(output logic [W-1:0] got, output int nv);
    got = '0; nv = 0;
    for (int j = 0; j < W; j++) begin
      if (tx_valid_o) nv++;
      got = {got[W-2:0], tx_bit_o};
      bit_valid_i = 1'b1; bit_i = j[0]; eod_i = (j == 3);
      @(negedge clk_i);
    end
    bit_valid_i = 1'b0; eod_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got, fcs;
    int nv;
    logic [63:0] frame;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 tx_valid", tx_valid_o, 0);
    chk("R1 tx_bit", tx_bit_o, 0);
    chk("R1 err_valid", err_valid_o, 0);
    chk("R1 err", err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (VECS[v]) begin
      fcs = poly_mod({12'b0, 32'b0, VECS[v].data} << W);
      if (VECS[v].md == 1'b0) begin
        send(1'b0, int'(VECS[v].len), {32'b0, VECS[v].data}, VECS[v].gaps);
        collect(got, nv);
        chk($sformatf("R3 R8 R10 fcs v%0d", v), got, fcs);
        chk($sformatf("R4 valid count v%0d", v), nv, W);
        chk($sformatf("R4 valid drop v%0d", v), tx_valid_o, 0);
      end else begin
        frame = (({32'b0, VECS[v].data} << W) | {52'b0, fcs}) ^ {20'b0, VECS[v].flip};
        send(1'b1, int'(VECS[v].len) + W, frame, VECS[v].gaps);
        chk($sformatf("R5 err_valid v%0d", v), err_valid_o, 1);
        chk($sformatf("R5 R6 err v%0d", v), err_o, VECS[v].exp_err);
        // R7 R9: stray bits after the frame leave the flag untouched
        for (int k = 0; k < 3; k++) begin
          bit_valid_i = 1'b1; bit_i = k[0]; eod_i = 1'b1;
          @(negedge clk_i);
        end
        bit_valid_i = 1'b0; eod_i = 1'b0;
        chk($sformatf("R7 R9 hold valid v%0d", v), err_valid_o, 1);
        chk($sformatf("R7 R9 hold err v%0d", v), err_o, VECS[v].exp_err);
      end
      @(negedge clk_i);
    end

    // R7: sof clears err_valid in the next cycle
    sof_i = 1'b1; mode_i = 1'b1;
    @(negedge clk_i);
    sof_i = 1'b0;
    chk("R7 sof clears err_valid", err_valid_o, 0);

    // R2: frame abandoned by a new sof; result follows the second frame only
    for (int k = 0; k < 5; k++) begin
      bit_valid_i = 1'b1; bit_i = 1'b1;
      @(negedge clk_i);
    end
    bit_valid_i = 1'b0;
    send(1'b0, 8, 64'h3C, 1'b0);
    collect(got, nv);
    chk("R2 restart fcs", got, poly_mod(76'h3C << W));

    // R2: sof during shift-out aborts it
    send(1'b0, 8, 64'h81, 1'b0);
    sof_i = 1'b1; mode_i = 1'b0;
    @(negedge clk_i);
    sof_i = 1'b0;
    chk("R2 sof aborts shift-out", tx_valid_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule